// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs clause-22 management frames to an external PHY over the two-wire MDC/MDIO management link. Software packs a complete frame into one 32-bit command word and writes it to the command register. That single write launches the frame. The block first sends a 32-bit preamble of ones. It then shifts out bits 31:16 of the command word and the 16-bit data field, most significant bit first. Each new bit is driven just after a falling edge of MDC.

For a read request, the block releases MDIO from the turnaround position onward. It then samples the PHY's 16 data bits on the rising edges of MDC. At completion the sampled value replaces the low half of the command register. Every completed frame sets a sticky event bit, and software clears that bit by writing a one to it. A divider register sets the MDC rate. MDC runs only while a frame is in flight and stays low otherwise.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, MDC is low, MDIO enable is low, MDIO out is high, and the event, command and divider registers all read zero.
- R2: A command write while idle starts a frame of 64 MDC periods. The frame is 32 ones, then command bits 31:16, then command bits 15:0, MSB first. MDIO out changes only on a falling MDC edge.
- R3: For a write frame, MDIO enable stays high for the whole frame. For a read frame (command bits 29:28 equal 2'b10), it drops for the last 18 MDC periods, from the turnaround pair onward.
- R4: The divider sits in bits DIV_W:1 of the divider register. Each MDC high phase and each low phase lasts that many clocks, so one period is twice the divider. MDC is low whenever no frame is in flight.
- R5: While the divider is zero, MDC holds its level and the frame does not advance. A later nonzero divider resumes the frame.
- R6: In a read frame, MDIO in is sampled at the MDC rising edges of the last 16 periods, first bit as MSB. On completion the result appears in command register bits 15:0, and bits 31:16 are kept.
- R7: At the clock edge that ends the last MDC period, event bit 23 becomes 1 and stays set. Writing a 1 to bit 23 of the event register clears it. Writing a 0 there has no effect.
- R8: A command write that arrives while a frame is in flight is ignored. The frame and the command register are unchanged.
- R9: The register map is: address 0 is the event register, address 1 is the command register, and address 2 is the divider register. A read returns data on reg_rdata one clock after reg_rd. Unused event bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The frame engine is run with three patterns:

- A write frame with a divider of 1. This separates the fixed ones preamble from the command-derived bits and shows that the enable is held for the whole frame.
- A read frame with a divider of 2. A PHY value is driven only in the data window, which shows the turnaround release and the rising-edge sampling order.
- A frame started with a divider of zero and later resumed at 3. This tells a frozen frame apart from one that restarts or skips bits.

A second command is written in the middle of the first frame to show that it is dropped. The event bit is then cleared with both a zero and a one written to bit 23.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_LEN  = 64;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    localparam int TA_IDX     = 46;
    localparam int DATA_IDX   = 48;
    localparam int EVT_BIT    = 23;
    localparam int ADDR_W     = 2;

    localparam logic [ADDR_W-1:0] ADR_EVT = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CMD = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_DIV = 2'd2;
    localparam logic [1:0]        OP_READ = 2'b10;

    typedef struct packed {
        logic                 busy;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_LEN-1:0] sh;
        logic [15:0]          rx;
        logic                 rd;
    } eng_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } ck_t;

    ck_t  st_d, st_q;
    logic term;

    always_comb begin
        st_d = st_q;
        term = (div_i != '0) && (st_q.cnt == div_i - 1'b1);
        if (!active_i) begin
            st_d = '0;
        end else if (div_i != '0) begin
            if (term) begin
                st_d.cnt = '0;
                st_d.mdc = ~st_q.mdc;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc_o  = st_q.mdc;
    assign rise_o = active_i & term & ~st_q.mdc;
    assign fall_o = active_i & term &  st_q.mdc;

    // R5
    mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && div_i == '0) |=> $stable(mdc_o));
    // R4
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !mdc_o);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [31:0] word_i,
    input  logic        rise_i,
    input  logic        fall_i,
    input  logic        mdio_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        rd_o,
    output logic [15:0] rdata_o,
    output logic        mdio_o,
    output logic        mdio_oe_o
);
    eng_t st_d, st_q;
    logic done;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (start_i && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.sh   = {{(FRAME_LEN-32){1'b1}}, word_i};
            st_d.rd   = (word_i[29:28] == OP_READ);
            st_d.rx   = '0;
        end else if (st_q.busy) begin
            if (rise_i && st_q.rd && st_q.idx >= IDX_W'(DATA_IDX))
                st_d.rx = {st_q.rx[14:0], mdio_i};
            if (fall_i) begin
                if (st_q.idx == IDX_W'(FRAME_LEN-1)) begin
                    st_d.busy = 1'b0;
                    done      = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                    st_d.sh  = st_q.sh << 1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o    = st_q.busy;
    assign done_o    = done;
    assign rd_o      = st_q.rd;
    assign rdata_o   = st_q.rx;
    assign mdio_o    = st_q.busy ? st_q.sh[FRAME_LEN-1] : 1'b1;
    assign mdio_oe_o = st_q.busy & ~(st_q.rd & (st_q.idx >= IDX_W'(TA_IDX)));

    // R2
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(st_q.idx) == IDX_W'(FRAME_LEN-1));
    // R5
    no_tick_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !fall_i) |=> $stable(st_q.idx));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    typedef struct packed {
        logic [31:0]      cmd;
        logic [DIV_W-1:0] div;
        logic             evt;
        logic [31:0]      rdata;
    } regs_t;

    regs_t       r_d, r_q;
    logic        cmd_wr, busy, done, rd_op, rise, fall;
    logic [15:0] rx;

    assign cmd_wr = reg_wr && reg_addr == ADR_CMD;

    mdio_clkdiv #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .active_i(busy), .div_i(r_q.div),
        .mdc_o(mdc), .rise_o(rise), .fall_o(fall)
    );

    mdio_frame_eng u_eng (
        .clk(clk), .rst_n(rst_n), .start_i(cmd_wr), .word_i(reg_wdata),
        .rise_i(rise), .fall_i(fall), .mdio_i(mdio_i),
        .busy_o(busy), .done_o(done), .rd_o(rd_op), .rdata_o(rx),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe)
    );

    always_comb begin
        r_d = r_q;
        if (cmd_wr && !busy)
            r_d.cmd = reg_wdata;
        if (done && rd_op)
            r_d.cmd[15:0] = rx;
        if (reg_wr && reg_addr == ADR_DIV)
            r_d.div = reg_wdata[DIV_W:1];
        if (reg_wr && reg_addr == ADR_EVT && reg_wdata[EVT_BIT])
            r_d.evt = 1'b0;
        if (done)
            r_d.evt = 1'b1;
        if (reg_rd) begin
            case (reg_addr)
                ADR_EVT: r_d.rdata = 32'(r_q.evt) << EVT_BIT;
                ADR_CMD: r_d.rdata = r_q.cmd;
                ADR_DIV: r_d.rdata = 32'({r_q.div, 1'b0});
                default: r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign reg_rdata = r_q.rdata;

    // R8
    busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && !done) |=> $stable(r_q.cmd));
    // R7
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> r_q.evt);
endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0, bad = 0, cyc = 0;

    // behavioural reference state
    bit          m_busy = 0, m_rd = 0, m_evt = 0;
    int          m_h = 0, m_hp = 0, m_div = 0;
    logic [63:0] m_frame = '0;
    logic [31:0] m_cmd = '0;
    logic [15:0] rdpat = 16'hBEEF;

    always #2 clk = ~clk;

    mdio_mgmt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model, advanced at every rising edge
    always @(posedge clk) begin
        if (rst_n) begin
            if (reg_wr && reg_addr == 2'd1 && !m_busy) begin
                m_busy = 1; m_h = 0; m_hp = 0;
                m_frame = {32'hFFFF_FFFF, reg_wdata};
                m_rd = (reg_wdata[29:28] == 2'b10);
                m_cmd = reg_wdata;
            end else if (m_busy && m_div != 0) begin
                m_hp++;
                if (m_hp == m_div) begin
                    m_hp = 0; m_h++;
                    if (m_h == 128) begin
                        m_busy = 0;
                        if (reg_wr && reg_addr == 2'd0 && reg_wdata[23]) m_evt = 0;
                        m_evt = 1;
                        if (m_rd) m_cmd[15:0] = rdpat;
                    end
                end
            end
            if (reg_wr && reg_addr == 2'd0 && reg_wdata[23] && !(m_busy == 0 && m_h == 128 && m_hp == 0))
                m_evt = 0;
            if (reg_wr && reg_addr == 2'd2) m_div = int'(reg_wdata[8:1]);
            if (!m_busy) m_h = 0;
        end
    end

    // per-clock comparison and PHY model, away from the active edge
    always @(negedge clk) begin
        int bi;
        cyc++;
        if (rst_n) begin
            bi = m_h / 2;
            chk("R4 mdc", 32'(mdc), 32'(m_busy ? m_h[0] : 1'b0));
            chk("R2 mdio_o", 32'(mdio_o), 32'(m_busy ? m_frame[63-bi] : 1'b1));
            chk("R3 mdio_oe", 32'(mdio_oe), 32'(m_busy && !(m_rd && bi >= 46)));
            mdio_i = (m_busy && m_rd && bi >= 48) ? rdpat[63-bi] : 1'b1;
        end
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] view(input logic [1:0] a);
        case (a)
            2'd0: return 32'(m_evt) << 23;
            2'd1: return m_cmd;
            2'd2: return 32'(m_div) << 1;
            default: return '0;
        endcase
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        reg_rd = 1; reg_addr = a; e = view(a);
        @(negedge clk);
        reg_rd = 0;
        chk(tag, reg_rdata, e);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && m_busy; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] wcmd, rcmd;
        repeat (3) @(negedge clk);
        chk("R1 mdc reset", 32'(mdc), 0);
        chk("R1 oe reset", 32'(mdio_oe), 0);
        chk("R1 mdio_o reset", 32'(mdio_o), 1);
        rst_n = 1;
        rd_chk(2'd0, "R1 evt reset");
        rd_chk(2'd1, "R1 cmd reset");
        rd_chk(2'd2, "R1 div reset");

        // write frame, divider 1
        wr(2'd2, 32'd2);
        rd_chk(2'd2, "R9 div readback");
        wcmd = 32'h5002_0000 | (32'd5 << 23) | (32'd3 << 18) | 32'h0000_A5C3;
        wr(2'd1, wcmd);
        repeat (20) @(negedge clk);
        wr(2'd1, 32'h6002_1111);
        rd_chk(2'd1, "R8 cmd unchanged mid-frame");
        wait_idle();
        rd_chk(2'd0, "R7 event set");
        rd_chk(2'd1, "R8 cmd after write frame");
        wr(2'd0, 32'h0000_0000);
        rd_chk(2'd0, "R7 zero write keeps event");
        wr(2'd0, 32'h0080_0000);
        rd_chk(2'd0, "R7 event cleared");

        // read frame, divider 2
        wr(2'd2, 32'd4);
        rcmd = 32'h6002_0000 | (32'd1 << 23) | (32'd2 << 18);
        wr(2'd1, rcmd);
        wait_idle();
        rd_chk(2'd1, "R6 read data in cmd");
        chk("R6 read value", m_cmd, {rcmd[31:16], 16'hBEEF});
        rd_chk(2'd0, "R7 event after read");
        wr(2'd0, 32'h0080_0000);

        // divider zero freezes the frame
        wr(2'd2, 32'd0);
        wr(2'd1, wcmd);
        repeat (30) @(negedge clk);
        chk("R5 mdc held", 32'(mdc), 0);
        chk("R5 preamble held", 32'(mdio_o), 1);
        rd_chk(2'd0, "R5 no completion");
        wr(2'd2, 32'd6);
        wait_idle();
        rd_chk(2'd0, "R5 resumed and completed");
        rd_chk(2'd3, "R9 unused address");

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule